// File: doc/BRIEF.md
# Extended Indexed Operand Address Generator

This block computes effective operand addresses for an indexed addressing mode in a 20-bit address space. It takes instruction-stream words one at a time over a valid/ready input. The first word is a prefix extension word. The second is the opcode. After these come one index word per indexed operand. For each indexed operand the block selects a base register through a register-read port. It builds a 20-bit index: the upper bits come from a field of the extension word and the lower 16 bits come from the index word. The base and the index are added modulo 2^20.

Each address is presented on an output with a valid/ready handshake. The output carries the address of the low word, the address of the following word (address + 2, used by 20-bit operands) and a flag that tells a source address from a destination address. When the instruction is complete, the block pulses a word count so that the fetch logic can advance the program counter by two bytes per word. The block never writes the register file. The base register therefore keeps its value.

Top module: `xidx_agen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block discards any partly received instruction. After that edge `in_ready`=1, `addr_valid`=0 and `adv_valid`=0, and the next accepted word is treated as an extension word.
- R2: In the extension word, bits [10:7] hold the upper 4 index bits of the source operand. Bits [3:0] hold the upper 4 index bits of the destination operand.
- R3: In the opcode word, bits [11:8] select the source base register, and the source is indexed when bits [5:4] equal 2'b01. Bits [3:0] select the destination base register, and the destination is indexed when bit 7 is 1. While the block waits for an index word, `rd_sel` shows the base register of that operand.
- R4: When an index word is accepted, `addr_lo` becomes `rd_data` + {upper field, index word} and `addr_valid` is high from the following cycle.
- R5: The sum wraps modulo 2^20. For example, base 23456h with index F8346h gives 1B79Ch.
- R6: `addr_hi` equals `addr_lo` + 2 modulo 2^20, for example FFFFEh gives 00000h.
- R7: When both operands are indexed, the source index word is consumed first. The source address (`addr_dst`=0) is output before the destination address (`addr_dst`=1).
- R8: While `addr_valid`=1 and `addr_ready`=0, the address outputs hold their values and `in_ready`=0.
- R9: One cycle after the last address is accepted, `adv_valid` is high for exactly one cycle. `adv_words` then equals 2 plus the number of indexed operands, which gives 3 or 4.
- R10: If the opcode marks no operand as indexed, no address is output. `adv_valid` pulses with `adv_words`=2 in the cycle after the opcode is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_word | input | 16 | Instruction-stream word |
| in_ready | output | 1 | Block accepts a word this cycle |
| rd_sel | output | 4 | Base register selected for reading |
| rd_data | input | 20 | Content of the selected register |
| addr_valid | output | 1 | Address output holds a result |
| addr_ready | input | 1 | Consumer takes the address |
| addr_lo | output | 20 | Effective operand address |
| addr_hi | output | 20 | Effective address plus 2 |
| addr_dst | output | 1 | 1 = destination address, 0 = source |
| adv_valid | output | 1 | One-cycle pulse at the end of an instruction |
| adv_words | output | 3 | Instruction words consumed |

## Verification
The bench targets several corner cases.

- A base plus index that crosses 2^20, and a low address of FFFFEh whose high word wraps to zero. An adder wider than 20 bits, or an upper field taken from the wrong bit position, would produce a wrong address there.
- A two-operand instruction whose consumer stalls. A block that swapped the order, reused the source upper field for the destination, or accepted words while an address was pending would show a wrong flag, a wrong sum or a moving output.
- An instruction with no indexed operand, and a reset in the middle of an instruction. The first exposes a stray address or a wrong word count. The second exposes stale fields that leak into the next instruction.

// File: rtl/xidx_pkg.sv
// Shared types and field positions for the extended indexed address generator.
// Assumes a 16-bit instruction word; field positions are fixed by the decoder contract.
package xidx_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_EXT  = 3'd0,   // waiting for the extension word
        ST_OP   = 3'd1,   // waiting for the opcode word
        ST_SIDX = 3'd2,   // waiting for the source index word
        ST_DIDX = 3'd3,   // waiting for the destination index word
        ST_OUT  = 3'd4,   // presenting an address
        ST_ADV  = 3'd5    // reporting the word count
    } xidx_state_t;

    // Extension word: upper index field positions
    localparam int EXT_SRC_LSB = 7;
    localparam int EXT_DST_LSB = 0;

    // Opcode word: register select and mode field positions
    localparam int OP_SREG_LSB  = 8;
    localparam int OP_DREG_LSB  = 0;
    localparam int OP_SMODE_LSB = 4;
    localparam int OP_DMODE_BIT = 7;
    localparam logic [1:0] SMODE_INDEXED = 2'b01;

endpackage

// File: rtl/xidx_adder.sv
// Modulo-2^W adder used for the base+index sum and the +2 word offset.
// Assumes both operands are already W bits wide; the carry out is dropped.
module xidx_adder #(
    parameter int W = 20
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);

    // Wrap-around sum
    always_comb begin
        s = a + b;
    end

endmodule

// File: rtl/xidx_outreg.sv
// Output register for the address pair and the operand role flag.
// Assumes the sequencer pulses load only when the output stage is free.
module xidx_outreg #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_dst,
    input  logic [AW-1:0] sum_lo,
    input  logic [AW-1:0] sum_hi,
    output logic [AW-1:0] addr_lo,
    output logic [AW-1:0] addr_hi,
    output logic          addr_dst
);

    // Capture a freshly computed address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo  <= '0;
            addr_hi  <= '0;
            addr_dst <= 1'b0;
        end else if (load) begin
            addr_lo  <= sum_lo;
            addr_hi  <= sum_hi;
            addr_dst <= load_dst;
        end
    end

endmodule

// File: rtl/xidx_ctrl.sv
// Instruction sequencer: accepts extension, opcode and index words in order,
// keeps the upper index fields and register selects, drives the output handshake
// and the word count. Assumes the decoder fields are already sliced by the top.
module xidx_ctrl
    import xidx_pkg::*;
#(
    parameter int UP_W  = 4,
    parameter int SEL_W = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [UP_W-1:0]  ext_src_up,
    input  logic [UP_W-1:0]  ext_dst_up,
    input  logic [SEL_W-1:0] op_sreg,
    input  logic [SEL_W-1:0] op_dreg,
    input  logic [1:0]       op_smode,
    input  logic             op_didx,
    input  logic             out_ready,
    output logic             in_ready,
    output logic [SEL_W-1:0] sel_reg,
    output logic [UP_W-1:0]  sel_up,
    output logic             load,
    output logic             load_dst,
    output logic             out_valid,
    output logic             adv_valid,
    output logic [CNT_W-1:0] adv_words
);

    xidx_state_t      state;
    xidx_state_t      after_out;
    logic [UP_W-1:0]  src_up, dst_up;
    logic [SEL_W-1:0] src_reg, dst_reg;
    logic             src_ix, dst_ix;
    logic [CNT_W-1:0] words;
    logic             accept;
    logic             op_src_ix;

    // Handshake and decode of the current word
    always_comb begin
        in_ready  = (state == ST_EXT) || (state == ST_OP) ||
                    (state == ST_SIDX) || (state == ST_DIDX);
        accept    = in_valid && in_ready;
        op_src_ix = (op_smode == SMODE_INDEXED);
        out_valid = (state == ST_OUT);
        adv_valid = (state == ST_ADV);
        adv_words = words;
    end

    // Operand selection for the register port and the adder
    always_comb begin
        if (state == ST_DIDX) begin
            sel_reg = dst_reg;
            sel_up  = dst_up;
        end else begin
            sel_reg = src_reg;
            sel_up  = src_up;
        end
        load     = accept && ((state == ST_SIDX) || (state == ST_DIDX));
        load_dst = (state == ST_DIDX);
    end

    // State sequence, field capture and word counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_EXT;
            after_out <= ST_ADV;
            src_up    <= '0;
            dst_up    <= '0;
            src_reg   <= '0;
            dst_reg   <= '0;
            src_ix    <= 1'b0;
            dst_ix    <= 1'b0;
            words     <= '0;
        end else begin
            case (state)
                ST_EXT: if (accept) begin
                    src_up <= ext_src_up;
                    dst_up <= ext_dst_up;
                    words  <= CNT_W'(1);
                    state  <= ST_OP;
                end
                ST_OP: if (accept) begin
                    src_reg <= op_sreg;
                    dst_reg <= op_dreg;
                    src_ix  <= op_src_ix;
                    dst_ix  <= op_didx;
                    words   <= words + CNT_W'(1);
                    if (op_src_ix)    state <= ST_SIDX;
                    else if (op_didx) state <= ST_DIDX;
                    else              state <= ST_ADV;
                end
                ST_SIDX: if (accept) begin
                    words     <= words + CNT_W'(1);
                    after_out <= dst_ix ? ST_DIDX : ST_ADV;
                    state     <= ST_OUT;
                end
                ST_DIDX: if (accept) begin
                    words     <= words + CNT_W'(1);
                    after_out <= ST_ADV;
                    state     <= ST_OUT;
                end
                ST_OUT: if (out_ready) begin
                    state <= after_out;
                end
                ST_ADV: begin
                    state <= ST_EXT;
                end
                default: state <= ST_EXT;
            endcase
        end
    end

    // The count pulse lasts a single cycle
    assert_adv_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv_valid |=> !adv_valid);

    // The reported count matches the decoded operand flags
    assert_adv_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv_valid |-> (adv_words == CNT_W'(2) + CNT_W'(src_ix) + CNT_W'(dst_ix)));

    // After a source address leaves, a pending destination comes next
    assert_src_then_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !load_dst && after_out == ST_DIDX) |=> (state == ST_DIDX && dst_ix));

endmodule

// File: rtl/xidx_agen.sv
// Top of the extended indexed address generator: slices the word fields,
// adds base register and assembled index modulo 2^ADDR_W and registers the result.
// Assumes rd_data returns the selected register in the same cycle.
module xidx_agen
    import xidx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int UP_W   = 4,
    parameter int SEL_W  = 4,
    parameter int CNT_W  = 3,
    localparam int ADDR_W = WORD_W + UP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic [SEL_W-1:0]  rd_sel,
    input  logic [ADDR_W-1:0] rd_data,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic              addr_dst,
    output logic              adv_valid,
    output logic [CNT_W-1:0]  adv_words
);

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    logic [UP_W-1:0]   sel_up;
    logic [ADDR_W-1:0] index, sum_lo, sum_hi;
    logic              load, load_dst;

    // Index assembly from the stored upper field and the live index word
    always_comb begin
        index = {sel_up, in_word};
    end

    xidx_ctrl #(
        .UP_W  (UP_W),
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .ext_src_up (in_word[EXT_SRC_LSB +: UP_W]),
        .ext_dst_up (in_word[EXT_DST_LSB +: UP_W]),
        .op_sreg    (in_word[OP_SREG_LSB +: SEL_W]),
        .op_dreg    (in_word[OP_DREG_LSB +: SEL_W]),
        .op_smode   (in_word[OP_SMODE_LSB +: 2]),
        .op_didx    (in_word[OP_DMODE_BIT]),
        .out_ready  (addr_ready),
        .in_ready   (in_ready),
        .sel_reg    (rd_sel),
        .sel_up     (sel_up),
        .load       (load),
        .load_dst   (load_dst),
        .out_valid  (addr_valid),
        .adv_valid  (adv_valid),
        .adv_words  (adv_words)
    );

    xidx_adder #(.W(ADDR_W)) u_sum_lo (
        .a (rd_data),
        .b (index),
        .s (sum_lo)
    );

    xidx_adder #(.W(ADDR_W)) u_sum_hi (
        .a (sum_lo),
        .b (WORD_STEP),
        .s (sum_hi)
    );

    xidx_outreg #(.AW(ADDR_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_dst (load_dst),
        .sum_lo   (sum_lo),
        .sum_hi   (sum_hi),
        .addr_lo  (addr_lo),
        .addr_hi  (addr_hi),
        .addr_dst (addr_dst)
    );

    // Address equals base plus assembled index, wrapped (R4, R5)
    assert_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_lo == ADDR_W'($past(rd_data) + {$past(sel_up), $past(in_word)})));

    // The second-word address lies two bytes above the first
    assert_word_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (ADDR_W'(addr_hi - addr_lo) == WORD_STEP));

    // A stalled address stays put and no word is taken
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_lo) && $stable(addr_dst) && !in_ready));

    // Completion report never overlaps a pending address
    assert_adv_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv_valid |-> !addr_valid);

endmodule

// File: tb/tb_xidx_agen.sv
`timescale 1ns/1ps
module tb_xidx_agen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_ready;
    logic [3:0]  rd_sel;
    logic [19:0] rd_data;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [19:0] addr_lo, addr_hi;
    logic        addr_dst;
    logic        adv_valid;
    logic [2:0]  adv_words;

    logic [19:0] regs [16];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign rd_data = regs[rd_sel];

    xidx_agen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .rd_sel(rd_sel), .rd_data(rd_data),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .addr_dst(addr_dst), .adv_valid(adv_valid),
        .adv_words(adv_words)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ext_w(input logic [3:0] su, input logic [3:0] du);
        return 16'((su << 7) | du);
    endfunction

    function automatic logic [15:0] op_w(input logic [3:0] sr, input logic [1:0] sm,
                                         input logic di, input logic [3:0] dr);
        return 16'((sr << 8) | (di << 7) | (sm << 4) | dr);
    endfunction

    task automatic send_word(input logic [15:0] w);
        in_valid = 1'b1;
        in_word  = w;
        for (int i = 0; i < 50 && !in_ready; i++) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_addr(input logic [19:0] lo, input logic dst, input bit hold, input string tag);
        for (int i = 0; i < 20 && !addr_valid; i++) @(negedge clk);
        check(addr_valid, {tag, " addr_valid"}, int'(addr_valid), 1);
        check(addr_lo == lo, {tag, " addr_lo"}, int'(addr_lo), int'(lo));
        check(addr_hi == 20'(lo + 20'd2), "R6 addr_hi", int'(addr_hi), int'(20'(lo + 20'd2)));
        check(addr_dst == dst, "R7 addr_dst", int'(addr_dst), int'(dst));
        if (hold) begin
            repeat (3) @(negedge clk);
            check(addr_valid && addr_lo == lo, "R8 held address", int'(addr_lo), int'(lo));
            check(!in_ready, "R8 in_ready while pending", int'(in_ready), 0);
        end
        addr_ready = 1'b1;
        @(negedge clk);
        addr_ready = 1'b0;
    endtask

    task automatic expect_adv(input logic [2:0] n, input string tag);
        bit stray = 0;
        for (int i = 0; i < 20 && !adv_valid; i++) begin
            if (addr_valid) stray = 1;
            @(negedge clk);
        end
        check(!stray, "R10 no address emitted", int'(stray), 0);
        check(adv_valid, {tag, " adv_valid"}, int'(adv_valid), 1);
        check(adv_words == n, {tag, " adv_words"}, int'(adv_words), int'(n));
        @(negedge clk);
        check(!adv_valid, "R9 single pulse", int'(adv_valid), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
        check(!addr_valid, "R1 addr_valid after reset", int'(addr_valid), 0);
        check(!adv_valid, "R1 adv_valid after reset", int'(adv_valid), 0);
    endtask

    // R2 R3 R4: source-only indexed operand
    task automatic test_src_only();
        regs[5] = 20'h15678;
        send_word(ext_w(4'h3, 4'h9));
        send_word(op_w(4'd5, 2'b01, 1'b0, 4'd6));
        check(rd_sel == 4'd5, "R3 rd_sel source", int'(rd_sel), 5);
        send_word(16'h2100);
        expect_addr(20'h15678 + 20'h32100, 1'b0, 0, "R4");
        expect_adv(3'd3, "R9 src only");
    endtask

    // R5 R6: destination-only with wrap, then high word wrap
    task automatic test_wrap();
        regs[6] = 20'h23456;
        send_word(ext_w(4'h0, 4'hF));
        send_word(op_w(4'd2, 2'b00, 1'b1, 4'd6));
        check(rd_sel == 4'd6, "R3 rd_sel dest", int'(rd_sel), 6);
        send_word(16'h8346);
        expect_addr(20'h1B79C, 1'b1, 0, "R5");
        expect_adv(3'd3, "R9 dst only");
        regs[7] = 20'hFFFF0;
        send_word(ext_w(4'h0, 4'h0));
        send_word(op_w(4'd7, 2'b01, 1'b0, 4'd0));
        send_word(16'h000E);
        expect_addr(20'hFFFFE, 1'b0, 0, "R6");
    endtask

    // R7 R8: both operands, distinct upper fields, stalled consumer
    task automatic test_both();
        regs[4] = 20'h00100;
        regs[9] = 20'h40000;
        send_word(ext_w(4'h1, 4'h2));
        send_word(op_w(4'd4, 2'b01, 1'b1, 4'd9));
        send_word(16'h0020);
        expect_addr(20'h10120, 1'b0, 1, "R7 source first");
        check(rd_sel == 4'd9, "R7 rd_sel dest second", int'(rd_sel), 9);
        send_word(16'h0030);
        expect_addr(20'h60030, 1'b1, 1, "R7 dest second");
        expect_adv(3'd4, "R9 both");
    endtask

    // R10: no indexed operand
    task automatic test_none();
        send_word(ext_w(4'h5, 4'h5));
        send_word(op_w(4'd1, 2'b10, 1'b0, 4'd2));
        expect_adv(3'd2, "R10");
    endtask

    // R1: reset during an instruction drops the stored fields
    task automatic test_reset_mid();
        send_word(ext_w(4'hA, 4'hA));
        send_word(op_w(4'd3, 2'b01, 1'b1, 4'd3));
        do_reset();
        regs[3] = 20'h00000;
        send_word(ext_w(4'h0, 4'h0));
        send_word(op_w(4'd3, 2'b01, 1'b0, 4'd0));
        send_word(16'h1234);
        expect_addr(20'h01234, 1'b0, 0, "R1 fresh instruction");
        expect_adv(3'd3, "R1 count");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 20'(i * 20'h01111);
        @(negedge clk);
        do_reset();
        test_src_only();
        test_wrap();
        test_both();
        test_none();
        test_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule